// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Flags

This block divides an integer held in a core's data registers. It takes one quotient bit per clock. It handles signed and unsigned operands in three forms. The word form divides a full-width dividend by a half-width divisor and returns remainder and quotient packed into one register. The narrow long form divides a full-width dividend by a full-width divisor. The wide long form divides a double-width dividend, built from two registers, by a full-width divisor. Both long forms return the quotient and the remainder in two separate registers.

The core issues a one-cycle `start` with the operands and the register indices. It then waits for `done`. Register write-back leaves on a single write port, in a fixed order. The port also carries the N, Z, V and C flag values and a divide-by-zero trap request. On quotient overflow the destination registers stay as they were. V is set, Z is cleared and N keeps the value the core supplied. C reads as clear after every division that completes. The register file and the exception entry sequence live outside this block.

Top module: `int_divider`

## Requirements
- R1: A `start` is accepted only while `busy` is low. `busy` stays high from the accepting edge through the cycle in which `done` is high. While `busy` is high, any `start` pulse and any change on the operand, mode or index inputs are ignored.
- R2: A zero divisor raises `done` and `divZero` together. The divisor counts as zero when its low W/2 bits are zero in the word form, or when all W bits are zero in a long form. No write strobe appears and `flagsValid` stays low.
- R3: On quotient overflow there is no write strobe. With `done`, the flags read V=1 and Z=0, and N equals the `oldN` sampled at the accepting edge.
- R4: Every division that does not trap raises `flagsValid` in its `done` cycle, and `flagC` reads 0 there.
- R5: Word form (`mode`=00): the dividend is `quoVal` and the divisor is bits W/2-1:0 of `divisor`; its upper half has no effect. Without overflow there is exactly one write, to `quoIdx`. That write carries the remainder in bits W-1:W/2 and the quotient in bits W/2-1:0. N is quotient bit W/2-1, Z is set when the W/2-bit quotient is zero, and V=0. Overflow occurs when an unsigned quotient exceeds 2^(W/2)-1, or when a signed quotient lies outside W/2-bit two's complement.
- R6: Wide long form (`mode`=10 or 11): the dividend is {`remVal`, `quoVal`}, with `remVal` as the upper W bits. Overflow occurs when the quotient does not fit in W bits, unsigned or two's complement as selected.
- R7: In either long form without overflow, the remainder is written to `remIdx` in one cycle. The quotient is written to `quoIdx` in the next cycle, together with `done`. When the two indices are equal, the quotient is the last value written.
- R8: Narrow long form (`mode`=01): the dividend is `quoVal`. N is quotient bit W-1, Z is set for a zero quotient, and V=0. The only overflow is a signed division of the most negative value by -1.
- R9: With `isSigned` high, the quotient truncates toward zero and a nonzero remainder takes the sign of the dividend. With `isSigned` low, all operands are unsigned.
- R10: `done` is high for one cycle. Count the accepting edge as edge 1. `done` is first visible after edge 1 for a trap, after edge 2W+2 for the word form or any overflow, and after edge 2W+3 for a long form that writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division (taken only when idle) |
| mode | input | 2 | 00 word form, 01 narrow long, 1x wide long |
| isSigned | input | 1 | Two's complement operands when high |
| quoIdx | input | IDX_W | Quotient (and packed word result) register index |
| remIdx | input | IDX_W | Remainder register index (long forms) |
| quoVal | input | W | Contents of the quotient register (dividend, low half in wide form) |
| remVal | input | W | Contents of the remainder register (dividend upper half, wide form) |
| divisor | input | W | Divisor operand |
| oldN | input | 1 | Current N flag, kept on overflow |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| divZero | output | 1 | Divide-by-zero trap request, with done |
| wbEn | output | 1 | Register write strobe |
| wbIdx | output | IDX_W | Register index of the write |
| wbData | output | W | Value written |
| flagsValid | output | 1 | Flag outputs meaningful (done without trap) |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |

## Verification
Each result has a fixed latency, counted in rising edges from the accepting edge. A trap shows after edge 1. A word-form or overflowing result shows after edge 2W+2. A long-form remainder write shows after edge 2W+2, and the quotient write with `done` after edge 2W+3. The bench counts edges from the accepting edge and samples every output on the falling edge that follows each one. It records each write strobe in the order seen and the edge number at which `done` appears. It then compares that edge number, the write list and the flags at `done` against values computed with plain integer division. The sweeps use an 8-bit configuration, so the full dividend and divisor space can be covered densely.

// File: rtl/int_div_pkg.sv
package int_div_pkg;

  // Operation form selector values
  localparam logic [1:0] MODE_WORD  = 2'b00;
  localparam logic [1:0] MODE_LONG  = 2'b01;

  // Strobes issued by the sequencer to the datapath, one set per cycle
  typedef struct packed {
    logic load;    // capture operands, prepare magnitudes
    logic step;    // one restoring-division iteration
    logic wrRem;   // present remainder write (long forms)
    logic wrQuo;   // present quotient / packed write
    logic finish;  // completion of a non-trapping division
    logic trap;    // completion of a zero-divisor request
  } divStrobe_t;

endpackage

// File: rtl/int_div_ctrl.sv
module int_div_ctrl
  import int_div_pkg::*;
#(
  parameter int STEPS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       divisorZero,
  input  logic       ovf,
  input  logic       isLong,
  output divStrobe_t st,
  output logic       busy
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RUN, S_POST, S_WREM, S_FIN, S_TRAP
  } ctrlState_t;

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (st.load)      stepCnt <= '0;
      else if (st.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    st        = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          st.load   = 1'b1;
          stateNext = divisorZero ? S_TRAP : S_RUN;
        end
      end
      S_RUN: begin
        st.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = S_POST;
      end
      S_POST: begin
        stateNext = (isLong && !ovf) ? S_WREM : S_FIN;
      end
      S_WREM: begin
        st.wrRem  = 1'b1;
        stateNext = S_FIN;
      end
      S_FIN: begin
        st.finish = 1'b1;
        st.wrQuo  = !ovf;
        stateNext = S_IDLE;
      end
      S_TRAP: begin
        st.trap   = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R1: the sequencer leaves idle only because of a start request
  p_busy_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R1: once busy, the block stays busy until its completion cycle
  p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !st.finish && !st.trap) |=> busy);

  // R7: the remainder write is always followed by the quotient write and completion
  p_rem_then_quo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrRem |=> (st.wrQuo && st.finish));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st.finish || st.trap) |=> !(st.finish || st.trap));

endmodule

// File: rtl/int_div_dpath.sv
module int_div_dpath
  import int_div_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  divStrobe_t       st,
  input  logic [1:0]       mode,
  input  logic             isSigned,
  input  logic [IDX_W-1:0] quoIdx,
  input  logic [IDX_W-1:0] remIdx,
  input  logic [W-1:0]     quoVal,
  input  logic [W-1:0]     remVal,
  input  logic [W-1:0]     divisor,
  input  logic             oldN,
  output logic             divisorZero,
  output logic             ovf,
  output logic             isLong,
  output logic             done,
  output logic             divZero,
  output logic             wbEn,
  output logic [IDX_W-1:0] wbIdx,
  output logic [W-1:0]     wbData,
  output logic             flagsValid,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC
);

  localparam int H  = W / 2;
  localparam int W2 = 2 * W;

  // ---------------- operand preparation (start cycle) ----------------
  logic          isWordIn, isWideIn;
  logic [W-1:0]  dvsRaw, dvsMagIn;
  logic          dvsNegIn;
  logic [W2-1:0] dvdRaw, dvdMagIn;
  logic          dvdNegIn;

  assign isWordIn = (mode == MODE_WORD);
  assign isWideIn = mode[1];

  always_comb begin
    if (isWordIn) dvsRaw = {{H{isSigned & divisor[H-1]}}, divisor[H-1:0]};
    else          dvsRaw = divisor;
    dvsNegIn = isSigned & dvsRaw[W-1];
    dvsMagIn = dvsNegIn ? ('0 - dvsRaw) : dvsRaw;

    if (isWideIn) dvdRaw = {remVal, quoVal};
    else          dvdRaw = {{W{isSigned & quoVal[W-1]}}, quoVal};
    dvdNegIn = isSigned & dvdRaw[W2-1];
    dvdMagIn = dvdNegIn ? ('0 - dvdRaw) : dvdRaw;
  end

  assign divisorZero = (dvsRaw == '0);

  // ---------------- iteration state ----------------
  logic [W-1:0]     partRem;
  logic [W2-1:0]    quoShift;
  logic [W-1:0]     dvsMag;
  logic             negQuo, negRem, sgnQ, isWordQ, nOld;
  logic [IDX_W-1:0] idxQuo, idxRem;

  logic [W:0] shifted, diff;
  logic       fitsSub;

  assign shifted = {partRem, quoShift[W2-1]};
  assign fitsSub = (shifted >= {1'b0, dvsMag});
  assign diff    = shifted - {1'b0, dvsMag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partRem  <= '0;
      quoShift <= '0;
      dvsMag   <= '0;
      negQuo   <= 1'b0;
      negRem   <= 1'b0;
      sgnQ     <= 1'b0;
      isWordQ  <= 1'b0;
      nOld     <= 1'b0;
      idxQuo   <= '0;
      idxRem   <= '0;
    end else if (st.load) begin
      partRem  <= '0;
      quoShift <= dvdMagIn;
      dvsMag   <= dvsMagIn;
      negQuo   <= dvdNegIn ^ dvsNegIn;
      negRem   <= dvdNegIn;
      sgnQ     <= isSigned;
      isWordQ  <= isWordIn;
      nOld     <= oldN;
      idxQuo   <= quoIdx;
      idxRem   <= remIdx;
    end else if (st.step) begin
      partRem  <= fitsSub ? diff[W-1:0] : shifted[W-1:0];
      quoShift <= {quoShift[W2-2:0], fitsSub};
    end
  end

  // ---------------- result shaping ----------------
  logic [W2-1:0] quoRes;
  logic [W-1:0]  remRes;
  logic          ovfWordU, ovfWordS, ovfLongU, ovfLongS;
  logic          quoNeg, quoZero;

  assign quoRes = negQuo ? ('0 - quoShift) : quoShift;
  assign remRes = negRem ? ('0 - partRem) : partRem;

  assign ovfWordU = |quoRes[W2-1:H];
  assign ovfWordS = !((quoRes[W2-1:H-1] == '0) || (quoRes[W2-1:H-1] == '1));
  assign ovfLongU = |quoRes[W2-1:W];
  assign ovfLongS = !((quoRes[W2-1:W-1] == '0) || (quoRes[W2-1:W-1] == '1));

  assign ovf    = isWordQ ? (sgnQ ? ovfWordS : ovfWordU)
                          : (sgnQ ? ovfLongS : ovfLongU);
  assign isLong = !isWordQ;

  assign quoNeg  = isWordQ ? quoRes[H-1] : quoRes[W-1];
  assign quoZero = isWordQ ? (quoRes[H-1:0] == '0) : (quoRes[W-1:0] == '0);

  // ---------------- write port and flags ----------------
  assign wbEn   = st.wrRem | st.wrQuo;
  assign wbIdx  = st.wrRem ? idxRem : idxQuo;
  always_comb begin
    if (st.wrRem)     wbData = remRes;
    else if (isWordQ) wbData = {remRes[H-1:0], quoRes[H-1:0]};
    else              wbData = quoRes[W-1:0];
  end

  assign done       = st.finish | st.trap;
  assign divZero    = st.trap;
  assign flagsValid = st.finish;
  assign flagN      = st.finish & (ovf ? nOld : quoNeg);
  assign flagZ      = st.finish & !ovf & quoZero;
  assign flagV      = st.finish & ovf;
  assign flagC      = 1'b0;

  // R2: a trapping request never writes and never presents flags
  p_trap_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st.trap |-> (!wbEn && !flagsValid));

  // R3: an overflowing division writes nothing, clears Z and keeps the sampled N
  p_ovf_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flagsValid && flagV) |-> (!wbEn && !flagZ && (flagN == nOld)));

  // R9: the final partial remainder magnitude lies below the divisor magnitude
  p_rem_below_divisor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrQuo |-> (partRem < dvsMag));

  // R6: an unsigned long quotient that is written fits in W bits
  p_long_quo_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wrQuo && !isWordQ && !sgnQ) |-> (quoShift[W2-1:W] == '0));

endmodule

// File: rtl/int_divider.sv
module int_divider
  import int_div_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             isSigned,
  input  logic [IDX_W-1:0] quoIdx,
  input  logic [IDX_W-1:0] remIdx,
  input  logic [W-1:0]     quoVal,
  input  logic [W-1:0]     remVal,
  input  logic [W-1:0]     divisor,
  input  logic             oldN,
  output logic             busy,
  output logic             done,
  output logic             divZero,
  output logic             wbEn,
  output logic [IDX_W-1:0] wbIdx,
  output logic [W-1:0]     wbData,
  output logic             flagsValid,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC
);

  localparam int STEPS = 2 * W;

  divStrobe_t strobes;
  logic       divisorZero, ovf, isLong;

  int_div_ctrl #(.STEPS(STEPS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .divisorZero (divisorZero),
    .ovf         (ovf),
    .isLong      (isLong),
    .st          (strobes),
    .busy        (busy)
  );

  int_div_dpath #(.W(W), .IDX_W(IDX_W)) dpath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (strobes),
    .mode        (mode),
    .isSigned    (isSigned),
    .quoIdx      (quoIdx),
    .remIdx      (remIdx),
    .quoVal      (quoVal),
    .remVal      (remVal),
    .divisor     (divisor),
    .oldN        (oldN),
    .divisorZero (divisorZero),
    .ovf         (ovf),
    .isLong      (isLong),
    .done        (done),
    .divZero     (divZero),
    .wbEn        (wbEn),
    .wbIdx       (wbIdx),
    .wbData      (wbData),
    .flagsValid  (flagsValid),
    .flagN       (flagN),
    .flagZ       (flagZ),
    .flagV       (flagV),
    .flagC       (flagC)
  );

endmodule

// File: tb/int_divider_tb_top.sv
`timescale 1ns/1ps
module int_divider_tb_top;

  localparam int TW = 8;
  localparam int TH = TW / 2;
  localparam int TI = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          isSigned = 1'b0;
  logic [TI-1:0] quoIdx = '0;
  logic [TI-1:0] remIdx = '0;
  logic [TW-1:0] quoVal = '0;
  logic [TW-1:0] remVal = '0;
  logic [TW-1:0] divisor = '0;
  logic          oldN = 1'b0;
  logic          busy, done, divZero, wbEn, flagsValid, flagN, flagZ, flagV, flagC;
  logic [TI-1:0] wbIdx;
  logic [TW-1:0] wbData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  int_divider #(.W(TW), .IDX_W(TI)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .isSigned(isSigned),
    .quoIdx(quoIdx), .remIdx(remIdx), .quoVal(quoVal), .remVal(remVal),
    .divisor(divisor), .oldN(oldN), .busy(busy), .done(done), .divZero(divZero),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData), .flagsValid(flagsValid),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] m, input logic s, input logic [TW-1:0] qv,
                       input logic [TW-1:0] rv, input logic [TW-1:0] dvIn,
                       input logic [TI-1:0] qi, input logic [TI-1:0] ri,
                       input logic on, input bit poke);
    longint dvd, dv, q, r, lo, hi;
    int lim, eLat, e, doneAt, nw;
    bit eTrap, eOvf, gotDone, okBusy;
    logic [TW-1:0] qb, rb;
    logic [TI-1:0] wI [2];
    logic [TW-1:0] wD [2];
    logic [23:0] eW, aW;
    logic [4:0] eF, aF;
    logic aDz;
    string mt;

    // ---- expected values from plain integer arithmetic ----
    if (m == 2'b00) begin
      dvd = s ? longint'($signed(qv)) : longint'(qv);
      dv  = s ? longint'($signed(dvIn[TH-1:0])) : longint'(dvIn[TH-1:0]);
      lim = TH; mt = "R5";
    end else if (m == 2'b01) begin
      dvd = s ? longint'($signed(qv)) : longint'(qv);
      dv  = s ? longint'($signed(dvIn)) : longint'(dvIn);
      lim = TW; mt = "R8 R7";
    end else begin
      dvd = s ? longint'($signed({rv, qv})) : longint'({rv, qv});
      dv  = s ? longint'($signed(dvIn)) : longint'(dvIn);
      lim = TW; mt = "R6 R7";
    end
    if (s) mt = {mt, " R9"};
    eTrap = (dv == 0);
    q = 0; r = 0; eOvf = 1'b0;
    if (!eTrap) begin
      q = dvd / dv;
      r = dvd % dv;
      if (s) begin lo = -(longint'(1) << (lim - 1)); hi = (longint'(1) << (lim - 1)) - 1; end
      else   begin lo = 0; hi = (longint'(1) << lim) - 1; end
      eOvf = (q < lo) || (q > hi);
    end
    qb = q[TW-1:0];
    rb = r[TW-1:0];
    if (eTrap)                  eLat = 1;
    else if (eOvf || m == 2'b00) eLat = 2 * TW + 2;
    else                         eLat = 2 * TW + 3;
    if (eTrap || eOvf)       eW = '0;
    else if (m == 2'b00)     eW = {2'd1, qi, rb[TH-1:0], qb[TH-1:0], {TI{1'b0}}, {TW{1'b0}}};
    else                     eW = {2'd2, ri, rb, qi, qb};
    if (eTrap) eF = '0;
    else eF = {1'b1,
               eOvf ? on : q[lim-1],
               !eOvf && ((q & ((longint'(1) << lim) - 1)) == 0),
               eOvf, 1'b0};

    // ---- drive and observe ----
    wI[0] = '0; wI[1] = '0; wD[0] = '0; wD[1] = '0;
    nw = 0; doneAt = 0; gotDone = 1'b0; okBusy = 1'b1; aF = '0; aDz = 1'b0;
    @(negedge clk);
    mode = m; isSigned = s; quoVal = qv; remVal = rv; divisor = dvIn;
    quoIdx = qi; remIdx = ri; oldN = on; start = 1'b1;
    @(posedge clk);
    e = 1;
    @(negedge clk);
    while (!gotDone && e < 40) begin
      if (!busy) okBusy = 1'b0;
      if (wbEn) begin
        if (nw < 2) begin wI[nw] = wbIdx; wD[nw] = wbData; end
        nw++;
      end
      if (done) begin
        gotDone = 1'b1; doneAt = e;
        aF = {flagsValid, flagN, flagZ, flagV, flagC};
        aDz = divZero;
      end
      if (poke && e == 3) begin
        start = 1'b1; divisor = '0; quoVal = ~quoVal; mode = 2'b00; quoIdx = ~quoIdx;
      end else begin
        start = 1'b0;
      end
      if (!gotDone) begin
        @(posedge clk); e++; @(negedge clk);
      end
    end
    start = 1'b0;
    aW = {nw[1:0], wI[0], wD[0], wI[1], wD[1]};

    chk(doneAt == eLat, $sformatf("R10 latency %s", mt), doneAt, eLat);
    chk(aDz == eTrap, "R2 divide-by-zero request", aDz, eTrap);
    chk(aW == eW, $sformatf("%s%s write sequence", eTrap ? "R2 " : (eOvf ? "R3 " : ""), mt), aW, eW);
    chk(aF == eF, $sformatf("%s flags %s", eTrap ? "R2" : (eOvf ? "R3 R4" : "R4"), mt), aF, eF);
    chk(okBusy, poke ? "R1 start while busy" : "R1 busy held", okBusy, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !wbEn && !flagsValid, "R1 reset state",
        {busy, done, wbEn, flagsValid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    runOp(2'b01, 1'b1, 8'h80, 8'h00, 8'hFF, 3'd1, 3'd2, 1'b1, 1'b0); // R8 only overflow case
    runOp(2'b01, 1'b1, 8'h80, 8'h00, 8'hFF, 3'd1, 3'd2, 1'b0, 1'b0); // R3 N kept low
    runOp(2'b00, 1'b1, 8'h80, 8'h00, 8'h3F, 3'd4, 3'd0, 1'b1, 1'b0); // R5 signed -128/-1
    runOp(2'b00, 1'b0, 8'hFF, 8'h00, 8'hA1, 3'd4, 3'd0, 1'b0, 1'b0); // R5 unsigned 255/1
    runOp(2'b00, 1'b0, 8'h37, 8'h00, 8'hF0, 3'd4, 3'd0, 1'b0, 1'b0); // R2 zero low half
    runOp(2'b10, 1'b0, 8'h12, 8'h34, 8'h00, 3'd4, 3'd0, 1'b0, 1'b0); // R2 wide zero
    runOp(2'b10, 1'b0, 8'hF3, 8'h05, 8'h09, 3'd6, 3'd6, 1'b0, 1'b0); // R7 equal indices
    runOp(2'b01, 1'b1, 8'h9D, 8'h00, 8'h07, 3'd3, 3'd3, 1'b0, 1'b0); // R7 R9 equal indices
    runOp(2'b11, 1'b1, 8'h00, 8'hC0, 8'h81, 3'd0, 3'd7, 1'b1, 1'b0); // R6 mode 11
    runOp(2'b10, 1'b0, 8'h00, 8'h09, 8'h09, 3'd0, 3'd7, 1'b1, 1'b0); // R6 just over W bits
    runOp(2'b01, 1'b0, 8'hC8, 8'h00, 8'h0B, 3'd2, 3'd5, 1'b0, 1'b1); // R1 poke while busy
    runOp(2'b00, 1'b1, 8'hE9, 8'h00, 8'h05, 3'd2, 3'd5, 1'b1, 1'b1); // R1 poke while busy

    // Word form sweep (R5, R9)
    for (int sg = 0; sg < 2; sg++)
      for (int a = 0; a < 256; a += 3)
        for (int d = 0; d < 16; d++)
          runOp(2'b00, sg[0], a[7:0], 8'h00, {a[3:0] ^ 4'h5, d[3:0]}, 3'd2, 3'd5, a[0], 1'b0);

    // Narrow long form sweep (R8, R9)
    for (int sg = 0; sg < 2; sg++)
      for (int a = 0; a < 256; a += 9)
        for (int d = 0; d < 256; d += 7)
          runOp(2'b01, sg[0], a[7:0], 8'h00, d[7:0], 3'd1, 3'd6, a[1], 1'b0);

    // Wide long form sweep (R6, R9)
    for (int sg = 0; sg < 2; sg++)
      for (int hIx = 0; hIx < 7; hIx++)
        for (int a = 0; a < 256; a += 51)
          for (int dIx = 0; dIx < 9; dIx++) begin
            logic [7:0] hv, dv;
            case (hIx)
              0: hv = 8'h00; 1: hv = 8'h01; 2: hv = 8'h03; 3: hv = 8'h7F;
              4: hv = 8'h80; 5: hv = 8'hFE; default: hv = 8'hFF;
            endcase
            case (dIx)
              0: dv = 8'h00; 1: dv = 8'h01; 2: dv = 8'h02; 3: dv = 8'h03; 4: dv = 8'h7F;
              5: dv = 8'h80; 6: dv = 8'hFF; 7: dv = 8'hFE; default: dv = 8'h05;
            endcase
            runOp(2'b10, sg[0], a[7:0], hv, dv, 3'd3, 3'd4, hv[0], 1'b0);
          end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule